// File: doc/BRIEF.md
# Program Address Sequencer with Interrupt Context

This block produces the 12-bit fetch address for a small 4-bit processor core. The decoder gives it one-cycle control strobes. The strobes cover sequential advance (one or two words), direct jump, subroutine call, subroutine return, indirect in-page jump, interrupt entry and interrupt return. The live program counter sits in one slot of an eight-slot circular address stack. The other seven slots hold return addresses.

The block also keeps two pieces of context that an interrupt must not disturb:
- the one-bit index-register bank select;
- the last address sent out by the send-register operation.

Interrupt entry saves both, switches to the alternate bank and vectors to a fixed handler. Interrupt return restores the program counter and the bank, and re-issues the saved send address with a one-cycle strobe. Every output is registered and changes on the clock edge that follows the strobe.

Top module: `pc_sequencer`

## Requirements
- R1: While `rstN` is low and on the first cycle after it, `fetchAddr` is 0, `bankSel` is 0, `sendOut` is 0, and `sendStrobe` and `stackOvf` are 0.
- R2: `stepEn` adds 1 to `fetchAddr`, or adds 2 when `stepDouble` is 1. The result wraps modulo 4096.
- R3: `jmpEn` loads `tgtAddr` into `fetchAddr`.
- R4: `callEn` stores `fetchAddr`+2 as a return address and loads `tgtAddr`. `retEn` moves the stack up by one level, so `fetchAddr` becomes the most recently stored return address.
- R5: Seven calls can nest. The seven returns then deliver their return addresses in reverse order of the calls.
- R6: A call or interrupt entry made while seven return addresses are stored overwrites the oldest one and sets `stackOvf`. `stackOvf` stays 1 until reset.
- R7: `jinEn` replaces `fetchAddr[7:0]` with `pairVal` and keeps `fetchAddr[11:8]`.
- R8: When `jinEn` is asserted with `fetchAddr[7:0]` = 8'hFF, the upper four bits become `fetchAddr[11:8]`+1, modulo 16.
- R9: `intEn` stores the current `fetchAddr` as a return address, loads 12'h003 and sets `bankSel` to 1.
- R10: `iretEn` returns `fetchAddr` to the value it had when `intEn` was taken. It also returns `bankSel` to the value it had then.
- R11: `sendCapEn` loads `sendVal` into `sendOut`. `iretEn` sets `sendOut` back to the value it held at interrupt entry and pulses `sendStrobe` for exactly one cycle.
- R12: When several control strobes are asserted together, the priority is `intEn`, then `jmpEn`, `callEn`, `retEn`, `jinEn`, `iretEn`, and last `stepEn`. Lower-priority strobes in that cycle have no effect.
- R13: `bankWrEn` loads `bankWrVal` into `bankSel`. A bank write in the same cycle as a taken `intEn` or `iretEn` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stepEn | input | 1 | Sequential advance strobe |
| stepDouble | input | 1 | Advance by two words instead of one |
| jmpEn | input | 1 | Direct jump strobe |
| callEn | input | 1 | Subroutine call strobe |
| retEn | input | 1 | Subroutine return strobe |
| jinEn | input | 1 | Indirect in-page jump strobe |
| intEn | input | 1 | Interrupt entry strobe |
| iretEn | input | 1 | Interrupt return strobe |
| tgtAddr | input | 12 | Jump and call target |
| pairVal | input | 8 | Register-pair value for the indirect jump |
| bankWrEn | input | 1 | Bank select write strobe |
| bankWrVal | input | 1 | Bank select write value |
| sendCapEn | input | 1 | Capture strobe for the send address |
| sendVal | input | 8 | Send address to capture |
| fetchAddr | output | 12 | Current program counter |
| bankSel | output | 1 | Index-register bank select |
| sendOut | output | 8 | Current or restored send address |
| sendStrobe | output | 1 | One-cycle re-issue pulse after interrupt return |
| stackOvf | output | 1 | Sticky return-stack overflow flag |

## Verification
An indirect jump is placed at 0x3FF and at 0xFFF. A design that keeps the instruction's own page would land on page 3 instead of page 4, and on page F instead of page 0. The stack is filled with eight calls and then unwound. A design without circular overwrite, or with a stack that is too shallow, would return wrong addresses or fail to set the sticky flag.

Interrupt tests change the bank and the send address inside the handler. A design that restores the wrong value, or none, leaves the handler's values visible after the return. Simultaneous strobes expose a wrong priority order as a wrong fetch address.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;

  typedef enum logic [2:0] {
    SEL_INC1,
    SEL_INC2,
    SEL_TGT,
    SEL_PAGE,
    SEL_VEC
  } nxt_sel_e;

  // Command from control to datapath
  typedef struct packed {
    logic     push;        // store return address, move to new live slot
    logic     pop;         // move live slot up one level
    logic     load;        // write next address into live slot
    logic     retPlusTwo;  // return address is fetch+2 (call) or fetch (interrupt)
    nxt_sel_e sel;
  } seq_cmd_t;

endpackage

// File: rtl/pc_seq_datapath.sv
module pc_seq_datapath
  import pc_seq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int PAGE_W = 8,
  parameter int DEPTH = 8,
  parameter logic [ADDR_W-1:0] HANDLER = 12'h003
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_cmd_t          cmd,
  input  logic [ADDR_W-1:0] tgtAddr,
  input  logic [PAGE_W-1:0] pairVal,
  output logic [ADDR_W-1:0] fetchAddr
);

  localparam int SP_W = $clog2(DEPTH);
  localparam int HI_W = ADDR_W - PAGE_W;

  logic [ADDR_W-1:0] stack [DEPTH];
  logic [SP_W-1:0]   sp;
  logic [SP_W-1:0]   spInc;
  logic [ADDR_W-1:0] nextAddr;
  logic [ADDR_W-1:0] retAddr;
  logic [HI_W-1:0]   pageHi;

  assign fetchAddr = stack[sp];
  assign spInc     = sp + SP_W'(1);
  assign retAddr   = cmd.retPlusTwo ? fetchAddr + ADDR_W'(2) : fetchAddr;

  // An indirect jump sitting on the last word of a page lands in the next page
  always_comb begin
    if (fetchAddr[PAGE_W-1:0] == {PAGE_W{1'b1}})
      pageHi = fetchAddr[ADDR_W-1:PAGE_W] + HI_W'(1);
    else
      pageHi = fetchAddr[ADDR_W-1:PAGE_W];
  end

  always_comb begin
    unique case (cmd.sel)
      SEL_INC1: nextAddr = fetchAddr + ADDR_W'(1);
      SEL_INC2: nextAddr = fetchAddr + ADDR_W'(2);
      SEL_TGT:  nextAddr = tgtAddr;
      SEL_PAGE: nextAddr = {pageHi, pairVal};
      SEL_VEC:  nextAddr = HANDLER;
      default:  nextAddr = fetchAddr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) stack[i] <= '0;
      sp <= '0;
    end else if (cmd.push) begin
      stack[sp]    <= retAddr;
      stack[spInc] <= nextAddr;
      sp           <= spInc;
    end else if (cmd.pop) begin
      sp <= sp - SP_W'(1);
    end else if (cmd.load) begin
      stack[sp] <= nextAddr;
    end
  end

  assert_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    $past(cmd.load && !cmd.push && cmd.sel == SEL_INC1) |-> fetchAddr == $past(fetchAddr) + ADDR_W'(1));

  assert_jin_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(cmd.load && cmd.sel == SEL_PAGE) |-> fetchAddr[PAGE_W-1:0] == $past(pairVal));

  assert_vector_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(cmd.push && cmd.sel == SEL_VEC) |-> fetchAddr == HANDLER);

  assert_jump_R3: assert property (@(posedge clk) disable iff (!rstN)
    $past(cmd.load && !cmd.push && cmd.sel == SEL_TGT) |-> fetchAddr == $past(tgtAddr));

endmodule

// File: rtl/pc_seq_ctrl.sv
module pc_seq_ctrl
  import pc_seq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int SEND_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stepEn,
  input  logic              stepDouble,
  input  logic              jmpEn,
  input  logic              callEn,
  input  logic              retEn,
  input  logic              jinEn,
  input  logic              intEn,
  input  logic              iretEn,
  input  logic              bankWrEn,
  input  logic              bankWrVal,
  input  logic              sendCapEn,
  input  logic [SEND_W-1:0] sendVal,
  output seq_cmd_t          cmd,
  output logic              bankSel,
  output logic [SEND_W-1:0] sendOut,
  output logic              sendStrobe,
  output logic              stackOvf
);

  localparam int MAX_RET = DEPTH - 1;
  localparam int CNT_W = $clog2(DEPTH);

  logic [CNT_W-1:0]  depth;
  logic              savedBank;
  logic [SEND_W-1:0] savedSend;
  logic              doInt;
  logic              doIret;

  // Priority decode: interrupt, jump, call, return, indirect, iret, step
  always_comb begin
    cmd   = '{push: 1'b0, pop: 1'b0, load: 1'b0, retPlusTwo: 1'b0, sel: SEL_INC1};
    doInt = 1'b0;
    doIret = 1'b0;
    if (intEn) begin
      cmd.push = 1'b1; cmd.sel = SEL_VEC; doInt = 1'b1;
    end else if (jmpEn) begin
      cmd.load = 1'b1; cmd.sel = SEL_TGT;
    end else if (callEn) begin
      cmd.push = 1'b1; cmd.sel = SEL_TGT; cmd.retPlusTwo = 1'b1;
    end else if (retEn) begin
      cmd.pop = 1'b1;
    end else if (jinEn) begin
      cmd.load = 1'b1; cmd.sel = SEL_PAGE;
    end else if (iretEn) begin
      cmd.pop = 1'b1; doIret = 1'b1;
    end else if (stepEn) begin
      cmd.load = 1'b1; cmd.sel = stepDouble ? SEL_INC2 : SEL_INC1;
    end
  end

  // Count of stored return addresses and sticky overflow
  always_ff @(posedge clk) begin
    if (!rstN) begin
      depth    <= '0;
      stackOvf <= 1'b0;
    end else if (cmd.push) begin
      if (depth == CNT_W'(MAX_RET)) stackOvf <= 1'b1;
      else depth <= depth + CNT_W'(1);
    end else if (cmd.pop && depth != '0) begin
      depth <= depth - CNT_W'(1);
    end
  end

  // Interrupt context: bank select and send address
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankSel    <= 1'b0;
      savedBank  <= 1'b0;
      sendOut    <= '0;
      savedSend  <= '0;
      sendStrobe <= 1'b0;
    end else begin
      sendStrobe <= doIret;
      if (doInt) begin
        savedBank <= bankSel;
        bankSel   <= 1'b1;
        savedSend <= sendOut;
      end else if (doIret) begin
        bankSel <= savedBank;
      end else if (bankWrEn) begin
        bankSel <= bankWrVal;
      end
      if (doIret) sendOut <= savedSend;
      else if (sendCapEn) sendOut <= sendVal;
    end
  end

  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(stackOvf) |-> stackOvf);

  assert_alt_bank_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(intEn) |-> bankSel);

  assert_strobe_cause_R11: assert property (@(posedge clk) disable iff (!rstN)
    sendStrobe |-> $past(iretEn && !intEn && !jmpEn && !callEn && !retEn && !jinEn));

  assert_strobe_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    (sendStrobe && !$past(iretEn, 2)) |=> !sendStrobe || $past(iretEn));

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pc_seq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int PAGE_W = 8,
  parameter int DEPTH = 8,
  parameter int SEND_W = 8,
  parameter logic [ADDR_W-1:0] HANDLER = 12'h003
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stepEn,
  input  logic              stepDouble,
  input  logic              jmpEn,
  input  logic              callEn,
  input  logic              retEn,
  input  logic              jinEn,
  input  logic              intEn,
  input  logic              iretEn,
  input  logic [ADDR_W-1:0] tgtAddr,
  input  logic [PAGE_W-1:0] pairVal,
  input  logic              bankWrEn,
  input  logic              bankWrVal,
  input  logic              sendCapEn,
  input  logic [SEND_W-1:0] sendVal,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic              bankSel,
  output logic [SEND_W-1:0] sendOut,
  output logic              sendStrobe,
  output logic              stackOvf
);

  seq_cmd_t cmd;

  pc_seq_ctrl #(.DEPTH(DEPTH), .SEND_W(SEND_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .stepEn(stepEn), .stepDouble(stepDouble), .jmpEn(jmpEn), .callEn(callEn),
    .retEn(retEn), .jinEn(jinEn), .intEn(intEn), .iretEn(iretEn),
    .bankWrEn(bankWrEn), .bankWrVal(bankWrVal),
    .sendCapEn(sendCapEn), .sendVal(sendVal),
    .cmd(cmd), .bankSel(bankSel), .sendOut(sendOut),
    .sendStrobe(sendStrobe), .stackOvf(stackOvf)
  );

  pc_seq_datapath #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DEPTH(DEPTH), .HANDLER(HANDLER)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .tgtAddr(tgtAddr), .pairVal(pairVal), .fetchAddr(fetchAddr)
  );

endmodule

// File: tb/pc_sequencer_bench.sv
module pc_sequencer_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        stepEn, stepDouble, jmpEn, callEn, retEn, jinEn, intEn, iretEn;
  logic [11:0] tgtAddr;
  logic [7:0]  pairVal;
  logic        bankWrEn, bankWrVal, sendCapEn;
  logic [7:0]  sendVal;
  logic [11:0] fetchAddr;
  logic        bankSel;
  logic [7:0]  sendOut;
  logic        sendStrobe, stackOvf;

  int nRun = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  pc_sequencer u_pc_sequencer (
    .clk(clk), .rstN(rstN),
    .stepEn(stepEn), .stepDouble(stepDouble), .jmpEn(jmpEn), .callEn(callEn),
    .retEn(retEn), .jinEn(jinEn), .intEn(intEn), .iretEn(iretEn),
    .tgtAddr(tgtAddr), .pairVal(pairVal),
    .bankWrEn(bankWrEn), .bankWrVal(bankWrVal),
    .sendCapEn(sendCapEn), .sendVal(sendVal),
    .fetchAddr(fetchAddr), .bankSel(bankSel), .sendOut(sendOut),
    .sendStrobe(sendStrobe), .stackOvf(stackOvf)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    stepEn = 0; stepDouble = 0; jmpEn = 0; callEn = 0; retEn = 0; jinEn = 0;
    intEn = 0; iretEn = 0; tgtAddr = '0; pairVal = '0;
    bankWrEn = 0; bankWrVal = 0; sendCapEn = 0; sendVal = '0;
  endtask

  // Inputs are set at a falling edge, held over one rising edge, then released
  task automatic tick();
    @(negedge clk);
    idle();
  endtask

  task automatic doReset();
    idle();
    rstN = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
  endtask

  task automatic jmpTo(input logic [11:0] a);
    jmpEn = 1; tgtAddr = a; tick();
  endtask

  task automatic testReset();
    idle();
    rstN = 0;
    @(negedge clk);
    check("R1 fetch in reset", fetchAddr, 0);
    rstN = 1;
    @(negedge clk);
    check("R1 fetch", fetchAddr, 0);
    check("R1 bank", bankSel, 0);
    check("R1 send", sendOut, 0);
    check("R1 strobe", sendStrobe, 0);
    check("R1 ovf", stackOvf, 0);
  endtask

  task automatic testStep();
    doReset();
    stepEn = 1; tick();
    check("R2 step by one", fetchAddr, 12'h001);
    stepEn = 1; stepDouble = 1; tick();
    check("R2 step by two", fetchAddr, 12'h003);
    jmpTo(12'hFFF);
    check("R3 jump", fetchAddr, 12'hFFF);
    stepEn = 1; tick();
    check("R2 wrap one", fetchAddr, 12'h000);
    jmpTo(12'hFFE);
    stepEn = 1; stepDouble = 1; tick();
    check("R2 wrap two", fetchAddr, 12'h000);
    tick();
    check("R2 hold when idle", fetchAddr, 12'h000);
  endtask

  task automatic testCall();
    doReset();
    jmpTo(12'h240);
    callEn = 1; tgtAddr = 12'h5A0; tick();
    check("R4 call target", fetchAddr, 12'h5A0);
    stepEn = 1; tick();
    retEn = 1; tick();
    check("R4 return", fetchAddr, 12'h242);
    check("R4 no ovf", stackOvf, 0);
  endtask

  task automatic testNest(input int calls);
    doReset();
    jmpTo(12'h100);
    for (int k = 1; k <= calls; k++) begin
      callEn = 1; tgtAddr = 12'h100 + 12'(16 * k); tick();
    end
    if (calls == 7) check("R5 seven deep no ovf", stackOvf, 0);
    else check("R6 ovf set", stackOvf, 1);
    for (int j = 1; j <= 7; j++) begin
      retEn = 1; tick();
      check(calls == 7 ? "R5 unwind" : "R6 unwind", fetchAddr,
            32'(12'h100 + 12'(16 * (calls - j)) + 12'd2));
    end
    if (calls == 8) begin
      stepEn = 1; tick();
      check("R6 ovf sticky", stackOvf, 1);
      doReset();
      check("R6 ovf cleared by reset", stackOvf, 0);
    end
  endtask

  task automatic testJin();
    doReset();
    jmpTo(12'h3A5);
    jinEn = 1; pairVal = 8'h17; tick();
    check("R7 in-page", fetchAddr, 12'h317);
    jmpTo(12'h3FF);
    jinEn = 1; pairVal = 8'h42; tick();
    check("R8 last word next page", fetchAddr, 12'h442);
    jmpTo(12'hFFF);
    jinEn = 1; pairVal = 8'h09; tick();
    check("R8 page wrap", fetchAddr, 12'h009);
  endtask

  task automatic testInt();
    doReset();
    jmpTo(12'h2A7);
    sendCapEn = 1; sendVal = 8'h5A; tick();
    check("R11 capture", sendOut, 8'h5A);
    intEn = 1; tick();
    check("R9 vector", fetchAddr, 12'h003);
    check("R9 alt bank", bankSel, 1);
    stepEn = 1; tick();
    sendCapEn = 1; sendVal = 8'h77; tick();
    check("R11 handler send", sendOut, 8'h77);
    check("R11 no strobe yet", sendStrobe, 0);
    iretEn = 1; tick();
    check("R10 pc restored", fetchAddr, 12'h2A7);
    check("R10 bank restored", bankSel, 0);
    check("R11 send restored", sendOut, 8'h5A);
    check("R11 strobe", sendStrobe, 1);
    tick();
    check("R11 strobe one cycle", sendStrobe, 0);
    // Bank 1 before interrupt, handler changes it
    bankWrEn = 1; bankWrVal = 1; tick();
    check("R13 bank write", bankSel, 1);
    intEn = 1; tick();
    bankWrEn = 1; bankWrVal = 0; tick();
    check("R13 bank write in handler", bankSel, 0);
    iretEn = 1; tick();
    check("R10 bank 1 restored", bankSel, 1);
  endtask

  task automatic testPriority();
    doReset();
    intEn = 1; jmpEn = 1; stepEn = 1; tgtAddr = 12'h700; bankWrEn = 1; bankWrVal = 0; tick();
    check("R12 int wins", fetchAddr, 12'h003);
    check("R13 bank write ignored at int", bankSel, 1);
    jmpEn = 1; callEn = 1; stepEn = 1; tgtAddr = 12'h700; tick();
    check("R12 jump over call and step", fetchAddr, 12'h700);
    retEn = 1; jinEn = 1; pairVal = 8'h33; tick();
    check("R12 return over indirect", fetchAddr, 12'h000);
    jinEn = 1; stepEn = 1; pairVal = 8'h44; tick();
    check("R12 indirect over step", fetchAddr, 12'h044);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    idle();
    rstN = 0;
    @(negedge clk);
    testReset();
    testStep();
    testCall();
    testNest(7);
    testNest(8);
    testJin();
    testInt();
    testPriority();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule